// File: doc/BRIEF.md
# Quadrature Power Custom-Instruction Unit

This block executes a small family of custom instructions beside a CPU pipeline. It sees every instruction word together with its two 32-bit source operands. When a word carries the custom major opcode and the custom function group, the block decodes it in the execute cycle. In that same cycle it reports whether the function code is unimplemented and which general-purpose register the result goes to.

The arithmetic takes the signed upper 16-bit half of each operand and forms the instantaneous power of a quadrature sample, which is the sum of the squared real and imaginary halves. Three variants exist: the full sum, the sum halved, and the real square alone. Each variant can also be compared against a 32-bit threshold held inside the block, and one instruction loads that threshold.

A parameter selects the timing. In single-cycle mode the result appears in the cycle after the start strobe. In pipelined mode the block raises a one-cycle stall, and the result follows one cycle after the stall ends. A late kill, qualified by the memory-stage run signal, cancels the stall of an instruction whose result will be discarded. It also cancels a pending threshold load.

Top module: `qpow_cx_unit`

## Requirements
- R1: An instruction belongs to the block only when the word is valid, bits [31:26] equal 6'd28 and bits [5:4] equal 2'b01. Any other word raises no illegal flag, names no register, raises no stall and does not change the result or the threshold.
- R2: In a start cycle with an owned instruction whose bits [3:0] are 7 to 15, the illegal flag is high and the destination output is 0. The illegal flag is low whenever the start strobe is low.
- R3: In a start cycle with an owned instruction of code 0, 1, 2, 4, 5 or 6, the destination output equals bits [15:11]. For code 3, and in every cycle without a start, it is 0.
- R4: Let a and b be the signed values of operand bits [31:16]. Code 0 returns a*a + b*b as an unsigned 32-bit value. Code 1 returns that sum shifted right by one.
- R5: Code 2 returns a*a, and the second operand has no effect on it.
- R6: Code 3 loads the full first operand into the threshold register and produces no result. Codes 4, 5 and 6 return 32'd1 when the code 0, 1 or 2 value is strictly greater than the threshold (unsigned), and 32'd0 otherwise, including on equality.
- R7: In single-cycle mode the result is on the result output in the cycle after the start strobe, and the stall output stays 0.
- R8: In pipelined mode the stall output is high only in the first cycle after the start of a result-producing instruction. It is low in the second cycle, and the result is on the output in the third cycle.
- R9: In pipelined mode, kill and run-M both high during the stall cycle drop the stall in that same cycle, and the result output keeps its previous value.
- R10: Kill and run-M both high in the cycle after a code 3 start leave the threshold unchanged.
- R11: Reset clears the threshold to 0 and the result output to 0. The present output is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word in execute |
| instr_vld_i | input | 1 | Instruction word is valid |
| start_i | input | 1 | Execute-stage start strobe |
| opa_i | input | 32 | First source operand, valid with start |
| opb_i | input | 32 | Second source operand, valid with start |
| kill_i | input | 1 | Late kill of the instruction in memory stage |
| run_m_i | input | 1 | Memory-stage run, qualifies kill |
| illegal_o | output | 1 | Unimplemented custom function, start cycle only |
| wr_reg_o | output | 5 | Destination register number, 0 means no write |
| result_o | output | 32 | Instruction result |
| stall_o | output | 1 | Pipeline hold request |
| present_o | output | 1 | Custom unit present, constant 1 |

## Verification
The embedded properties watch the decode outputs on every cycle. They check that the illegal flag and the destination number appear only in start cycles, and that the two are never active together. In pipelined mode they also check that a result-producing start is followed by a stall unless it is killed, and that the stall never lasts two cycles. The arithmetic values, the strict threshold comparison at equality, the forwarding of a just-loaded threshold, and the effect of a kill on the threshold and on the pipelined result need known operands and a reference model. Only the directed scenarios of the bench can show those.

// File: rtl/qpow_pkg.sv
package qpow_pkg;
    localparam int QP_DW     = 32;
    localparam int QP_HW     = QP_DW / 2;
    localparam int QP_RW     = 5;
    localparam int QP_FW     = 4;
    localparam logic [5:0] QP_MAJOR = 6'd28;
    localparam logic [1:0] QP_GROUP = 2'b01;
    localparam logic [QP_FW-1:0] QP_LAST_OP = 4'd6;

    typedef enum logic [QP_FW-1:0] {
        OP_PWR      = 4'd0,
        OP_PWR_HALF = 4'd1,
        OP_SQ_RE    = 4'd2,
        OP_THR_LD   = 4'd3,
        OP_CMP_PWR  = 4'd4,
        OP_CMP_HALF = 4'd5,
        OP_CMP_SQ   = 4'd6
    } op_e;

    typedef struct packed {
        logic [QP_DW-1:0] thr;
        logic             thr_pend;
        logic [QP_DW-1:0] thr_new;
        logic             s1_vld;
        op_e              s1_op;
        logic [QP_DW-1:0] s1_a2;
        logic [QP_DW-1:0] s1_b2;
        logic             s2_vld;
        op_e              s2_op;
        logic [QP_DW-1:0] s2_val;
        logic [QP_DW-1:0] res;
    } qp_state_t;

    function automatic logic [QP_DW-1:0] qp_finalize(input logic [QP_DW-1:0] val,
                                                     input op_e op,
                                                     input logic [QP_DW-1:0] thr);
        if (op == OP_CMP_PWR || op == OP_CMP_HALF || op == OP_CMP_SQ)
            return {{(QP_DW-1){1'b0}}, (val > thr)};
        return val;
    endfunction
endpackage

// File: rtl/qpow_decode.sv
module qpow_decode
    import qpow_pkg::*;
(
    input  logic [QP_DW-1:0] instr_i,
    input  logic             instr_vld_i,
    input  logic             start_i,
    output logic             exec_o,
    output logic             exec_wr_o,
    output logic             thr_ld_o,
    output logic             illegal_o,
    output logic [QP_RW-1:0] wr_reg_o,
    output op_e              op_o
);
    logic owned;
    logic legal;

    always_comb begin
        owned     = instr_vld_i && (instr_i[31:26] == QP_MAJOR) && (instr_i[5:4] == QP_GROUP);
        legal     = (instr_i[QP_FW-1:0] <= QP_LAST_OP);
        op_o      = op_e'(instr_i[QP_FW-1:0]);
        exec_o    = start_i && owned && legal;
        illegal_o = start_i && owned && !legal;
        thr_ld_o  = exec_o && (op_o == OP_THR_LD);
        exec_wr_o = exec_o && (op_o != OP_THR_LD);
        wr_reg_o  = exec_wr_o ? instr_i[15:11] : '0;
    end
endmodule

// File: rtl/qpow_square.sv
module qpow_square #(
    parameter int HW = 16,
    parameter int DW = 32
) (
    input  logic [HW-1:0] half_i,
    output logic [DW-1:0] sq_o
);
    logic signed [DW-1:0] ext;

    always_comb begin
        ext  = {{(DW-HW){half_i[HW-1]}}, half_i};
        sq_o = ext * ext;
    end
endmodule

// File: rtl/qpow_combine.sv
module qpow_combine
    import qpow_pkg::*;
(
    input  logic [QP_DW-1:0] a2_i,
    input  logic [QP_DW-1:0] b2_i,
    input  op_e              op_i,
    output logic [QP_DW-1:0] val_o
);
    logic [QP_DW-1:0] sum;

    always_comb begin
        sum = a2_i + b2_i;
        unique case (op_i)
            OP_PWR, OP_CMP_PWR:       val_o = sum;
            OP_PWR_HALF, OP_CMP_HALF: val_o = sum >> 1;
            OP_SQ_RE, OP_CMP_SQ:      val_o = a2_i;
            default:                  val_o = '0;
        endcase
    end
endmodule

// File: rtl/qpow_cx_unit.sv
module qpow_cx_unit
    import qpow_pkg::*;
#(
    parameter bit PIPELINED = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [QP_DW-1:0] instr_i,
    input  logic             instr_vld_i,
    input  logic             start_i,
    input  logic [QP_DW-1:0] opa_i,
    input  logic [QP_DW-1:0] opb_i,
    input  logic             kill_i,
    input  logic             run_m_i,
    output logic             illegal_o,
    output logic [QP_RW-1:0] wr_reg_o,
    output logic [QP_DW-1:0] result_o,
    output logic             stall_o,
    output logic             present_o
);
    localparam int NUM_SRC = 2;

    qp_state_t        st_d, st_q;
    logic             exec, exec_wr, thr_ld, killed;
    op_e              op;
    logic [QP_DW-1:0] sq [NUM_SRC];
    logic [QP_DW-1:0] cmb_a2, cmb_b2, cmb_val, thr_eff;
    op_e              cmb_op;

    qpow_decode u_decode (
        .instr_i     (instr_i),
        .instr_vld_i (instr_vld_i),
        .start_i     (start_i),
        .exec_o      (exec),
        .exec_wr_o   (exec_wr),
        .thr_ld_o    (thr_ld),
        .illegal_o   (illegal_o),
        .wr_reg_o    (wr_reg_o),
        .op_o        (op)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sq
        qpow_square #(.HW(QP_HW), .DW(QP_DW)) u_sq (
            .half_i ((g == 0) ? opa_i[QP_DW-1:QP_HW] : opb_i[QP_DW-1:QP_HW]),
            .sq_o   (sq[g])
        );
    end

    if (PIPELINED) begin : g_pipe_in
        assign cmb_a2 = st_q.s1_a2;
        assign cmb_b2 = st_q.s1_b2;
        assign cmb_op = st_q.s1_op;
        assign stall_o = st_q.s1_vld && !killed;
    end else begin : g_flat_in
        assign cmb_a2 = sq[0];
        assign cmb_b2 = sq[1];
        assign cmb_op = op;
        assign stall_o = 1'b0;
    end

    qpow_combine u_combine (
        .a2_i  (cmb_a2),
        .b2_i  (cmb_b2),
        .op_i  (cmb_op),
        .val_o (cmb_val)
    );

    assign killed    = kill_i && run_m_i;
    assign thr_eff   = (st_q.thr_pend && !killed) ? st_q.thr_new : st_q.thr;
    assign result_o  = st_q.res;
    assign present_o = 1'b1;

    always_comb begin
        st_d          = st_q;
        st_d.thr_pend = 1'b0;
        if (st_q.thr_pend && !killed)
            st_d.thr = st_q.thr_new;
        if (thr_ld) begin
            st_d.thr_pend = 1'b1;
            st_d.thr_new  = opa_i;
        end
        if (PIPELINED) begin
            st_d.s1_vld = exec_wr;
            if (exec_wr) begin
                st_d.s1_a2 = sq[0];
                st_d.s1_b2 = sq[1];
                st_d.s1_op = op;
            end
            st_d.s2_vld = st_q.s1_vld && !killed;
            if (st_q.s1_vld && !killed) begin
                st_d.s2_val = cmb_val;
                st_d.s2_op  = st_q.s1_op;
            end
            if (st_q.s2_vld)
                st_d.res = qp_finalize(st_q.s2_val, st_q.s2_op, thr_eff);
        end else begin
            if (exec_wr)
                st_d.res = qp_finalize(cmb_val, op, thr_eff);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_ILLEGAL_ONLY_ON_START: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> start_i);                                     // R2
    AST_DEST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start_i |-> (wr_reg_o == '0));                             // R3
    AST_ILLEGAL_NO_DEST: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (wr_reg_o == '0));                            // R2

    if (PIPELINED) begin : g_pipe_chk
        AST_STALL_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
            exec_wr |=> (stall_o || (kill_i && run_m_i)));          // R8
        AST_STALL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            stall_o |=> !stall_o);                                  // R8
        AST_KILL_DROPS_STALL: assert property (@(posedge clk) disable iff (rst)
            (kill_i && run_m_i) |-> !stall_o);                      // R9
    end
endmodule

// File: tb/qpow_cx_unit_tb.sv
module qpow_cx_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0, opa = '0, opb = '0;
    logic        vld = 1'b0, start = 1'b0, kill = 1'b0, run_m = 1'b0;
    logic        ill_s, ill_p, stall_s, stall_p, pres_s, pres_p;
    logic [4:0]  wr_s, wr_p;
    logic [31:0] res_s, res_p;

    int nchk = 0, nerr = 0;
    bit done = 1'b0;
    logic [31:0] thr_m = '0, exp_s = '0, exp_p = '0;

    always #2.5 clk = ~clk;

    qpow_cx_unit #(.PIPELINED(1'b0)) u_dut (
        .clk(clk), .rst(rst), .instr_i(instr), .instr_vld_i(vld), .start_i(start),
        .opa_i(opa), .opb_i(opb), .kill_i(kill), .run_m_i(run_m),
        .illegal_o(ill_s), .wr_reg_o(wr_s), .result_o(res_s), .stall_o(stall_s),
        .present_o(pres_s));

    qpow_cx_unit #(.PIPELINED(1'b1)) u_dut_pipe (
        .clk(clk), .rst(rst), .instr_i(instr), .instr_vld_i(vld), .start_i(start),
        .opa_i(opa), .opb_i(opb), .kill_i(kill), .run_m_i(run_m),
        .illegal_o(ill_p), .wr_reg_o(wr_p), .result_o(res_p), .stall_o(stall_p),
        .present_o(pres_p));

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sqv(input logic [15:0] h);
        logic signed [31:0] e;
        e = $signed(h);
        return e * e;
    endfunction

    function automatic logic [31:0] model(input logic [3:0] fn, input logic [31:0] a,
                                          input logic [31:0] b, input logic [31:0] t);
        logic [31:0] v;
        case (fn % 4'd4)
            4'd0:    v = sqv(a[31:16]) + sqv(b[31:16]);
            4'd1:    v = (sqv(a[31:16]) + sqv(b[31:16])) >> 1;
            default: v = sqv(a[31:16]);
        endcase
        if (fn >= 4'd4) v = (v > t) ? 32'd1 : 32'd0;
        return v;
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] fn, input logic [4:0] rd);
        return {6'd28, 5'd1, 5'd2, rd, 5'd0, 2'b01, fn};
    endfunction

    // one instruction through the full protocol, checking both timing variants
    task automatic issue(input string req, input logic [31:0] ir, input logic [31:0] a,
                         input logic [31:0] b, input bit v, input bit k);
        bit ours, legal, writes;
        logic [3:0] fn;
        fn     = ir[3:0];
        ours   = v && ir[31:26] == 6'd28 && ir[5:4] == 2'b01;
        legal  = ours && fn <= 4'd6;
        writes = legal && fn != 4'd3;
        @(negedge clk);
        instr = ir; opa = a; opb = b; vld = v; start = 1'b1;
        #1;
        chk(req, "illegal (single)", 32'(ill_s), 32'(ours && !legal));
        chk(req, "illegal (pipe)", 32'(ill_p), 32'(ours && !legal));
        chk(req, "dest reg", 32'(wr_s), writes ? 32'(ir[15:11]) : 32'd0);
        if (writes) begin
            exp_s = model(fn, a, b, thr_m);
            if (!k) exp_p = exp_s;
        end
        @(negedge clk);
        start = 1'b0; vld = 1'b0; kill = k; run_m = k;
        #1;
        chk(req, "single result next cycle", res_s, exp_s);
        chk(req, "single stall", 32'(stall_s), 32'd0);
        chk(req, "pipe stall cycle 1", 32'(stall_p), 32'(writes && !k));
        if (legal && fn == 4'd3 && !k) thr_m = a;
        @(negedge clk);
        kill = 1'b0; run_m = 1'b0;
        #1;
        chk(req, "pipe stall cycle 2", 32'(stall_p), 32'd0);
        @(negedge clk);
        #1;
        chk(req, "pipe result cycle 3", res_p, exp_p);
    endtask

    task automatic t_reset;
        chk("R11", "result after reset (single)", res_s, 32'd0);
        chk("R11", "result after reset (pipe)", res_p, 32'd0);
        chk("R11", "present", 32'({pres_s, pres_p}), 32'd3);
        chk("R7", "stall after reset", 32'({stall_s, stall_p}), 32'd0);
        // threshold is zero: any nonzero power compares greater
        issue("R11", mk(4'd4, 5'd3), 32'h0001_0000, 32'h0, 1'b1, 1'b0);
        chk("R11", "reset threshold compare", res_s, 32'd1);
    endtask

    task automatic t_foreign;
        issue("R1", {6'd0, 20'h12345, 6'b010000}, 32'h0005_0000, 32'h0005_0000, 1'b1, 1'b0);
        issue("R1", {6'd28, 20'h0F800, 6'b100000}, 32'h0005_0000, 32'h0, 1'b1, 1'b0);
        issue("R1", mk(4'd0, 5'd9), 32'h0005_0000, 32'h0, 1'b0, 1'b0);
        issue("R1", mk(4'd3, 5'd0), 32'h0, 32'h0, 1'b0, 1'b0);
        chk("R1", "threshold untouched by invalid load", res_s, 32'd1);
    endtask

    task automatic t_illegal;
        issue("R2", mk(4'd7, 5'd4), 32'h0, 32'h0, 1'b1, 1'b0);
        issue("R2", mk(4'd15, 5'd31), 32'h0, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_power;
        issue("R4 R7 R8", mk(4'd0, 5'd5), 32'h0003_AAAA, 32'h0004_5555, 1'b1, 1'b0);
        chk("R4", "3^2+4^2", res_p, 32'd25);
        issue("R4", mk(4'd0, 5'd6), 32'h8000_0000, 32'h8000_FFFF, 1'b1, 1'b0);
        chk("R4", "most negative halves", res_s, 32'h8000_0000);
        issue("R4", mk(4'd1, 5'd7), 32'hFFFF_0000, 32'h0005_0000, 1'b1, 1'b0);
        issue("R4", mk(4'd1, 5'd8), 32'h7FFF_0000, 32'h8000_0000, 1'b1, 1'b0);
        issue("R5 R3", mk(4'd2, 5'd31), 32'hFFF6_1234, 32'h7FFF_0000, 1'b1, 1'b0);
        chk("R5", "square ignores second operand", res_s, 32'd100);
    endtask

    task automatic t_threshold;
        issue("R6 R3", mk(4'd3, 5'd12), 32'hBEAF_DEAD, 32'h0, 1'b1, 1'b0);
        issue("R6", mk(4'd4, 5'd1), 32'h7FFF_0000, 32'h7FFF_0000, 1'b1, 1'b0);
        issue("R6", mk(4'd5, 5'd1), 32'h7FFF_0000, 32'h7FFF_0000, 1'b1, 1'b0);
        issue("R6", mk(4'd6, 5'd1), 32'h8000_0000, 32'h0, 1'b1, 1'b0);
        chk("R6", "below high threshold", res_s, 32'd0);
        issue("R6", mk(4'd3, 5'd0), 32'd25, 32'h0, 1'b1, 1'b0);
        issue("R6", mk(4'd4, 5'd2), 32'h0003_0000, 32'h0004_0000, 1'b1, 1'b0);
        chk("R6", "equal is not greater", res_p, 32'd0);
        issue("R6", mk(4'd4, 5'd2), 32'h0003_0000, 32'h0005_0000, 1'b1, 1'b0);
        issue("R6", mk(4'd5, 5'd2), 32'h0007_0000, 32'h0001_0000, 1'b1, 1'b0);
        issue("R6", mk(4'd6, 5'd2), 32'h0006_0000, 32'h0, 1'b1, 1'b0);
        chk("R6", "above threshold", res_s, 32'd1);
    endtask

    task automatic t_kill;
        issue("R9", mk(4'd0, 5'd10), 32'h0010_0000, 32'h0010_0000, 1'b1, 1'b1);
        chk("R9", "pipe result held after kill", res_p, 32'd1);
        issue("R10", mk(4'd3, 5'd0), 32'h0, 32'h0, 1'b1, 1'b1);
        issue("R10", mk(4'd4, 5'd11), 32'h0003_0000, 32'h0004_0000, 1'b1, 1'b0);
        chk("R10", "killed load left threshold", res_s, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_foreign();
        t_illegal();
        t_power();
        t_threshold();
        t_kill();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule